// File: doc/BRIEF.md
# Hold and Max/Min Reading Controller

This block sits between a converter that produces signed readings and the display logic of a meter. It keeps the latest valid reading and, when asked, the running maximum and minimum of the readings that follow. It picks the value presented on the display: live, maximum or minimum. A hold mode freezes that value and tells the converter to stop converting.

Three keys drive it, and each is synchronised and debounced. The hold key toggles hold. The max/min key moves from live display to maximum on its first short press, then swaps between minimum and maximum on each later short press. Holding that key for the long-press time returns the display to live. The clear key cancels both hold and max/min mode. All timing constants are parameters counted in clock ticks, so a fast simulation can scale them down.

Top module: `hold_minmax_ctrl`

## Requirements
- R1: While rst_ni is low, and after it rises, the display value is 0, hold is off, freeze_o is 0 and both max_flag_o and min_flag_o are 0 (live mode).
- R2: A key level that is stable for fewer than DEB_TICKS cycles after synchronisation never reaches the controller, so it changes no output.
- R3: A debounced max/min or hold press lasting fewer than MIN_PRESS_TICKS cycles is ignored.
- R4: In live mode with hold off, the display shows the most recent reading strobed by rd_valid_i, two cycles after the strobe.
- R5: A short max/min press in live mode enters max mode (max_flag_o=1) and seeds both the maximum and the minimum with the current live reading.
- R6: In max mode a short press selects min mode (min_flag_o=1). In min mode a short press selects max mode.
- R7: A max/min press that lasts LONG_PRESS_TICKS cycles returns to live mode when it reaches that length, and its release does not count as a short press.
- R8: In max or min mode, each valid reading updates the maximum and the minimum using a two's-complement signed comparison.
- R9: A reading with rd_ovr_i=1 does not change the maximum or the minimum.
- R10: A hold press of at least MIN_PRESS_TICKS toggles hold. While hold is on, freeze_o=1, hold_flag_o=1, the displayed value stays constant, and neither the live reading nor the extremes are updated.
- R11: A debounced clear key forces live mode and turns hold off, and it overrides any key event in the same cycle.
- R12: max_flag_o and min_flag_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_key_i | input | 1 | Raw hold key level, 1 = pressed |
| mm_key_i | input | 1 | Raw max/min key level, 1 = pressed |
| clr_key_i | input | 1 | Raw clear key level, 1 = pressed |
| rd_valid_i | input | 1 | Strobe: rd_value_i holds a new reading |
| rd_value_i | input | W | Signed reading in two's complement |
| rd_ovr_i | input | 1 | Reading is over range |
| disp_value_o | output | W | Signed value shown on the display |
| hold_flag_o | output | 1 | Hold annunciator |
| max_flag_o | output | 1 | Max annunciator |
| min_flag_o | output | 1 | Min annunciator |
| freeze_o | output | 1 | Asks the converter to stop while hold is on |

## Verification
A table of signed readings is fed in max mode. It mixes positive, negative, full-scale (+2047 and -2048) and over-range entries. An unsigned comparison would keep 0x800 as the maximum, and an update path that ignores the over-range flag would take the over-range values. Short pulses of two lengths separate the debounce filter from the minimum press length. A long max/min press confirms the return to live mode without a spurious swap when the key is released. The hold tests feed a new reading while frozen, and the clear tests run with max mode and hold both active.

// File: rtl/hm_pkg.sv
package hm_pkg;
  typedef enum logic [1:0] {
    MD_LIVE = 2'd0,
    MD_MAX  = 2'd1,
    MD_MIN  = 2'd2
  } disp_mode_e;

  localparam int NKEYS    = 3;
  localparam int KEY_HOLD = 0;
  localparam int KEY_MM   = 1;
  localparam int KEY_CLR  = 2;
endpackage

// File: rtl/hm_debounce.sv
module hm_debounce #(
  parameter int TICKS = 32000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == state_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q   <= '0;
        state_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = state_q;

  // level may only move after a full run of differing samples
  p_deb_settle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/hm_press.sv
module hm_press #(
  parameter int MIN_TICKS  = 50000,
  parameter int LONG_TICKS = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic short_o,
  output logic long_o
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] MIN_C  = CW'(MIN_TICKS);
  localparam logic [CW-1:0] LONG_C = CW'(LONG_TICKS);

  logic [CW-1:0] cnt_q;
  logic          level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      level_q <= level_i;
      if (!level_i)            cnt_q <= '0;
      else if (cnt_q != LONG_C) cnt_q <= cnt_q + 1'b1;
    end
  end

  // cnt_q equals the press length at the falling edge
  assign short_o = level_q && !level_i && (cnt_q >= MIN_C) && (cnt_q < LONG_C);
  assign long_o  = level_i && (cnt_q == LONG_C - 1'b1);

  p_long_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_o |=> !long_o);
endmodule

// File: rtl/hm_extreme.sv
module hm_extreme #(
  parameter int W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                seed_i,
  input  logic signed [W-1:0] seed_val_i,
  input  logic                upd_i,
  input  logic signed [W-1:0] val_i,
  output logic signed [W-1:0] max_o,
  output logic signed [W-1:0] min_o
);
  logic signed [W-1:0] max_q, min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= '0;
      min_q <= '0;
    end else if (seed_i) begin
      max_q <= seed_val_i;
      min_q <= seed_val_i;
    end else if (upd_i) begin
      if (val_i > max_q) max_q <= val_i;
      if (val_i < min_q) min_q <= val_i;
    end
  end

  assign max_o = max_q;
  assign min_o = min_q;

  p_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_q >= min_q);
endmodule

// File: rtl/hold_minmax_ctrl.sv
module hold_minmax_ctrl
  import hm_pkg::*;
#(
  parameter int W                = 12,
  parameter int DEB_TICKS        = 32000,
  parameter int MIN_PRESS_TICKS  = 50000,
  parameter int LONG_PRESS_TICKS = 1000000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_key_i,
  input  logic         mm_key_i,
  input  logic         clr_key_i,
  input  logic         rd_valid_i,
  input  logic [W-1:0] rd_value_i,
  input  logic         rd_ovr_i,
  output logic [W-1:0] disp_value_o,
  output logic         hold_flag_o,
  output logic         max_flag_o,
  output logic         min_flag_o,
  output logic         freeze_o
);
  logic [NKEYS-1:0] raw, lvl;
  assign raw = {clr_key_i, mm_key_i, hold_key_i};

  for (genvar k = 0; k < NKEYS; k++) begin : g_deb
    hm_debounce #(.TICKS(DEB_TICKS)) u_deb (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw[k]), .level_o(lvl[k])
    );
  end

  logic hold_short, hold_long, mm_short, mm_long;

  hm_press #(.MIN_TICKS(MIN_PRESS_TICKS), .LONG_TICKS(LONG_PRESS_TICKS)) u_press_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(lvl[KEY_HOLD]),
    .short_o(hold_short), .long_o(hold_long)
  );
  hm_press #(.MIN_TICKS(MIN_PRESS_TICKS), .LONG_TICKS(LONG_PRESS_TICKS)) u_press_mm (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(lvl[KEY_MM]),
    .short_o(mm_short), .long_o(mm_long)
  );

  disp_mode_e          mode_q;
  logic                hold_q;
  logic signed [W-1:0] live_q, disp_q, max_v, min_v, sel_v;
  logic                clr, hold_evt, seed, upd;

  assign clr      = lvl[KEY_CLR];
  assign hold_evt = hold_short || hold_long;  // a very long hold press toggles at the long mark
  assign seed     = !clr && !mm_long && mm_short && (mode_q == MD_LIVE);
  assign upd      = rd_valid_i && !rd_ovr_i && !hold_q && (mode_q != MD_LIVE) && !seed;

  hm_extreme #(.W(W)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .seed_i(seed), .seed_val_i(live_q),
    .upd_i(upd), .val_i($signed(rd_value_i)), .max_o(max_v), .min_o(min_v)
  );

  always_comb begin
    unique case (mode_q)
      MD_MAX:  sel_v = max_v;
      MD_MIN:  sel_v = min_v;
      default: sel_v = live_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_LIVE;
      hold_q <= 1'b0;
      live_q <= '0;
      disp_q <= '0;
    end else begin
      if (rd_valid_i && !hold_q) live_q <= $signed(rd_value_i);
      if (!hold_q) disp_q <= sel_v;
      if (clr) begin
        mode_q <= MD_LIVE;
        hold_q <= 1'b0;
      end else begin
        if (hold_evt) hold_q <= !hold_q;
        if (mm_long) mode_q <= MD_LIVE;
        else if (mm_short) mode_q <= (mode_q == MD_MAX) ? MD_MIN : MD_MAX;
      end
    end
  end

  assign disp_value_o = disp_q;
  assign hold_flag_o  = hold_q;
  assign freeze_o     = hold_q;
  assign max_flag_o   = (mode_q == MD_MAX);
  assign min_flag_o   = (mode_q == MD_MIN);

  p_flags_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({max_flag_o, min_flag_o}));
  p_frozen_disp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(freeze_o) |-> $stable(disp_value_o));
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!max_flag_o && !min_flag_o && !hold_flag_o));
  p_long_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_long && !clr) |=> (mode_q == MD_LIVE));
  p_enter_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed |=> (max_flag_o && (max_v == $past(live_q)) && (min_v == $past(live_q))));
  p_ovr_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ovr_i && !seed) |=> ($stable(max_v) && $stable(min_v)));
endmodule

// File: tb/hold_minmax_ctrl_tb.sv
`timescale 1ns/1ps
module hold_minmax_ctrl_tb;
  localparam int W    = 12;
  localparam int DEB  = 4;
  localparam int MINP = 12;
  localparam int LONG = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_k = 0, mm_k = 0, clr_k = 0, vld = 0, ovr = 0;
  logic [W-1:0] val = '0;
  logic [W-1:0] disp;
  logic hold_f, max_f, min_f, frz;
  int runs = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hold_minmax_ctrl #(.W(W), .DEB_TICKS(DEB), .MIN_PRESS_TICKS(MINP),
                     .LONG_PRESS_TICKS(LONG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hold_key_i(hold_k), .mm_key_i(mm_k),
    .clr_key_i(clr_k), .rd_valid_i(vld), .rd_value_i(val), .rd_ovr_i(ovr),
    .disp_value_o(disp), .hold_flag_o(hold_f), .max_flag_o(max_f),
    .min_flag_o(min_f), .freeze_o(frz)
  );

  typedef struct packed {
    logic signed [W-1:0] v;
    logic                o;
    logic signed [W-1:0] emax;
    logic signed [W-1:0] emin;
  } vec_t;

  // seeded with 100; signed tracking, over-range skipped
  localparam vec_t VECS [7] = '{
    '{-12'sd50,   1'b0, 12'sd100,  -12'sd50},
    '{12'sd300,   1'b0, 12'sd300,  -12'sd50},
    '{12'sd1500,  1'b1, 12'sd300,  -12'sd50},
    '{-12'sd2048, 1'b0, 12'sd300,  -12'sd2048},
    '{12'sd2047,  1'b0, 12'sd2047, -12'sd2048},
    '{-12'sd1000, 1'b1, 12'sd2047, -12'sd2048},
    '{12'sd5,     1'b0, 12'sd2047, -12'sd2048}
  };

  task automatic chk(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic signed [W-1:0] v, input logic o);
    @(negedge clk); vld = 1; val = v; ovr = o;
    @(negedge clk); vld = 0; ovr = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tap_mm(input int len);
    @(negedge clk); mm_k = 1;
    repeat (len) @(negedge clk);
    mm_k = 0;
    repeat (30) @(negedge clk);
  endtask

  task automatic tap_hold(input int len);
    @(negedge clk); hold_k = 1;
    repeat (len) @(negedge clk);
    hold_k = 0;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 disp", $signed(disp), 0);
    chk("R1 flags", {hold_f, max_f, min_f, frz}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {hold_f, max_f, min_f, frz}, 0);

    // R4
    send(-12'sd7, 0);
    chk("R4 live neg", $signed(disp), -7);
    send(12'sd100, 0);
    chk("R4 live", $signed(disp), 100);

    // R2: glitch filtered, R3: short press rejected
    tap_mm(3);
    chk("R2 glitch", {max_f, min_f}, 0);
    tap_mm(8);
    chk("R3 short press", {max_f, min_f}, 0);

    // R5
    tap_mm(20);
    chk("R5 max flag", {max_f, min_f}, 2'b10);
    chk("R5 seed", $signed(disp), 100);

    // R8 R9 table walk in max mode
    for (int i = 0; i < 7; i++) begin
      send(VECS[i].v, VECS[i].o);
      chk(VECS[i].o ? "R9 max" : "R8 max", $signed(disp), int'(VECS[i].emax));
    end

    // R6
    tap_mm(20);
    chk("R6 min flag", {max_f, min_f}, 2'b01);
    chk("R8 min", $signed(disp), int'(VECS[6].emin));
    tap_mm(20);
    chk("R6 back to max", {max_f, min_f}, 2'b10);

    // R7
    tap_mm(80);
    chk("R7 live after long", {max_f, min_f}, 0);
    chk("R7 display live", $signed(disp), 5);

    // R10
    send(12'sd123, 0);
    tap_hold(20);
    chk("R10 freeze", {hold_f, frz}, 2'b11);
    send(12'sd456, 0);
    chk("R10 frozen disp", $signed(disp), 123);
    tap_hold(8);
    chk("R3 hold short press", {hold_f, frz}, 2'b11);
    tap_hold(20);
    chk("R10 released", {hold_f, frz}, 0);
    chk("R10 live not taken", $signed(disp), 123);
    send(12'sd456, 0);
    chk("R10 live resumes", $signed(disp), 456);

    // R11
    tap_mm(20);
    tap_hold(20);
    chk("R11 setup", {hold_f, max_f}, 2'b11);
    @(negedge clk); clr_k = 1;
    repeat (20) @(negedge clk);
    clr_k = 0;
    repeat (10) @(negedge clk);
    chk("R11 cleared", {hold_f, max_f, min_f, frz}, 0);
    chk("R12 flags", int'(max_f & min_f), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule